// File: doc/BRIEF.md
# Endian Conversion Bus Bridge

This bridge sits between a CPU-side request port and a downstream memory or device port. It rewrites each single-beat transaction so that software running in either byte order sees memory as it expects. Each transaction gets one of three treatments. The first is straight pass-through. The second is a lane swap that depends on access width and leaves the address alone. The third is an address rewrite that XORs the low address bits and leaves the data lanes alone.

Two control inputs choose the treatment: a CPU byte-order bit and a system byte-order bit. Any request whose address falls inside an inclusive peripheral window is never converted. The controls and the window bounds are captured when a request is accepted, and they stay fixed for that transaction. Write data and strobes are converted on the way down. Read data is converted back with the same mapping on the way up. Only one transaction is in flight at a time. Misaligned requests get an error response and are never forwarded.

Top module: `endian_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and both `mem_valid` and `rsp_valid` are 0.
- R2: In swap mode the address goes downstream unchanged and the lanes are permuted by size. Size encoding is 0 = byte, 1 = halfword, 2 = word. Size 0 leaves all lanes in place. Size 1 exchanges bytes [31:24]<->[23:16] and [15:8]<->[7:0]. Size 2 reverses all four bytes. The write strobes move exactly as their data bytes do.
- R3: Swap mode applies whenever `cpu_big` = 1, whatever `sys_little` is. With `cpu_big` = 0 and `sys_little` = 1, address, data and strobes pass through unchanged.
- R4: With `cpu_big` = 0 and `sys_little` = 0 the address is rewritten. Its low three bits are XORed with 3'b111 for a byte, 3'b110 for a halfword and 3'b100 for a word. Data and strobes are unchanged.
- R5: A request with `win_base` <= address <= `win_limit` is forwarded with no conversion in any mode.
- R6: Read data returned on `rsp_rdata` passes back through the same lane mapping that was chosen for that transaction.
- R7: `cpu_big`, `sys_little`, `win_base` and `win_limit` are sampled in the accepting cycle. Later changes do not affect that transaction in either direction.
- R8: A misaligned request gets a response with `rsp_err` = 1 and `rsp_rdata` = 0, and nothing is issued downstream. Misaligned means a halfword at an odd address, a word whose address bits [1:0] are not zero, or size 3.
- R9: `req_ready` is high only when the bridge is idle. A downstream request keeps its value until `mem_ready`. `rsp_valid` lasts exactly one cycle.
- R10: Swap is its own inverse. A word written and then read at the same address, both in swap mode, reads back the original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_big | input | 1 | CPU byte order, 1 = big-endian |
| sys_little | input | 1 | System byte order, 1 = little-endian |
| win_base | input | ADDR_W | Lowest address of the bypass window |
| win_limit | input | ADDR_W | Highest address of the bypass window |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Write byte strobes |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_rdata | output | DATA_W | Read data after conversion |
| rsp_err | output | 1 | Misaligned request rejected |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream accepts request |
| mem_addr | output | ADDR_W | Downstream address |
| mem_size | output | 2 | Downstream size code |
| mem_write | output | 1 | Downstream write flag |
| mem_wdata | output | DATA_W | Downstream write data |
| mem_strb | output | DATA_W/8 | Downstream strobes |
| mem_rsp_valid | input | 1 | Downstream response valid |
| mem_rsp_rdata | input | DATA_W | Downstream read data |

## Verification
The critical overlap is a change of the byte-order controls or the window bounds while a transaction is still in flight. The bench provokes it by flipping both control bits and moving the window in the cycle right after acceptance, while the downstream side is still stalling with random ready delays. The forwarded address, data and strobes, and the returned read data, are judged against the mode that was in force at acceptance. A second overlap is a request inside the window issued while swap or address-rewrite mode is active. There, the window must win.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        XM_PASS  = 2'd0,
        XM_SWAP  = 2'd1,
        XM_MUNGE = 2'd2
    } xlate_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DOWN = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } br_state_e;

    typedef struct packed {
        xlate_mode_e mode;
        logic        misaligned;
    } decode_t;

    typedef struct packed {
        xlate_mode_e mode;
        acc_size_e   size;
    } txn_ctx_t;

    // Low-bit mask spanning one access of the given size.
    function automatic logic [7:0] size_mask(acc_size_e s);
        return (8'd1 << s) - 8'd1;
    endfunction

endpackage

// File: rtl/ebr_decode.sv
module ebr_decode
    import ebr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              cpu_big,
    input  logic              sys_little,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output decode_t           dec
);
    logic in_window;
    logic [ADDR_W-1:0] low_bits;

    assign in_window = (addr >= win_base) && (addr <= win_limit);
    assign low_bits  = addr & ADDR_W'(size_mask(size));

    always_comb begin
        dec.misaligned = (size == SZ_BAD) || (low_bits != '0);
        if (in_window)
            dec.mode = XM_PASS;
        else if (cpu_big)
            dec.mode = XM_SWAP;
        else if (!sys_little)
            dec.mode = XM_MUNGE;
        else
            dec.mode = XM_PASS;
    end
endmodule

// File: rtl/ebr_lane_xform.sv
module ebr_lane_xform
    import ebr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               en,
    input  acc_size_e          size,
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   sin,
    output logic [LANES*8-1:0] dout,
    output logic [LANES-1:0]   sout
);
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LIDX_W-1:0] flip;
    assign flip = en ? LIDX_W'(size_mask(size)) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LIDX_W-1:0] src;
        assign src = LIDX_W'(i) ^ flip;
        assign dout[i*8 +: 8] = din[src*8 +: 8];
        assign sout[i]        = sin[src];
    end
endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
    import ebr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_big,
    input  logic                sys_little,
    input  logic [ADDR_W-1:0]   win_base,
    input  logic [ADDR_W-1:0]   win_limit,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_strb,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic                mem_write,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W/8-1:0] mem_strb,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] MUNGE_SPAN = ADDR_W'(2 * LANES - 1);

    br_state_e   state;
    txn_ctx_t    ctx;
    decode_t     dec;
    acc_size_e   in_size;
    logic        accept;
    logic [DATA_W-1:0] dn_data, up_data;
    logic [LANES-1:0]  dn_strb, up_strb_unused;
    logic [ADDR_W-1:0] munged_addr;

    assign in_size   = acc_size_e'(req_size);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_valid = (state == ST_DOWN);
    assign rsp_valid = (state == ST_RESP);
    assign munged_addr = req_addr ^ (MUNGE_SPAN & ~ADDR_W'(size_mask(in_size)));

    ebr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cpu_big   (cpu_big),
        .sys_little(sys_little),
        .win_base  (win_base),
        .win_limit (win_limit),
        .addr      (req_addr),
        .size      (in_size),
        .dec       (dec)
    );

    ebr_lane_xform #(.LANES(LANES)) u_down (
        .en  (dec.mode == XM_SWAP),
        .size(in_size),
        .din (req_wdata),
        .sin (req_strb),
        .dout(dn_data),
        .sout(dn_strb)
    );

    ebr_lane_xform #(.LANES(LANES)) u_up (
        .en  (ctx.mode == XM_SWAP),
        .size(ctx.size),
        .din (mem_rsp_rdata),
        .sin ('0),
        .dout(up_data),
        .sout(up_strb_unused)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '0;
            mem_addr  <= '0;
            mem_size  <= '0;
            mem_write <= 1'b0;
            mem_wdata <= '0;
            mem_strb  <= '0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    ctx <= '{mode: dec.mode, size: in_size};
                    if (dec.misaligned) begin
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '0;
                        state     <= ST_RESP;
                    end else begin
                        rsp_err   <= 1'b0;
                        mem_addr  <= (dec.mode == XM_MUNGE) ? munged_addr : req_addr;
                        mem_size  <= req_size;
                        mem_write <= req_write;
                        mem_wdata <= dn_data;
                        mem_strb  <= dn_strb;
                        state     <= ST_DOWN;
                    end
                end
                ST_DOWN: if (mem_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    rsp_rdata <= up_data;
                    state     <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic port_misal, port_inwin;
    assign port_misal = (req_size == 2'd3) || (req_size == 2'd1 && req_addr[0])
                        || (req_size == 2'd2 && req_addr[1:0] != 2'b00);
    assign port_inwin = (req_addr >= win_base) && (req_addr <= win_limit);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_strb));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid || rsp_valid) |-> !req_ready);

    assert_reject_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && port_misal |=> rsp_valid && rsp_err && !mem_valid && rsp_rdata == '0);

    assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && port_inwin && !port_misal
        |=> mem_valid && mem_addr == $past(req_addr) && mem_wdata == $past(req_wdata));

    assert_wordswap_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && cpu_big && !port_inwin && req_size == 2'd2 && !port_misal
        |=> mem_addr == $past(req_addr)
            && mem_wdata[7:0]   == $past(req_wdata[31:24])
            && mem_wdata[31:24] == $past(req_wdata[7:0])
            && mem_wdata[15:8]  == $past(req_wdata[23:16]));

    assert_bytemunge_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !cpu_big && !sys_little && !port_inwin && req_size == 2'd0
        |=> mem_addr == ($past(req_addr) ^ ADDR_W'(7)) && mem_wdata == $past(req_wdata));
endmodule

// File: tb/tb_endian_bridge.sv
module tb_endian_bridge;
    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic        cpu_big = 0, sys_little = 0;
    logic [31:0] win_base = 32'h40, win_limit = 32'h4F;
    logic        req_valid = 0, req_write = 0;
    logic        req_ready;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [1:0]  req_size = 0;
    logic [3:0]  req_strb = 0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_write;
    logic        mem_ready = 0, mem_rsp_valid = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rsp_rdata = 0;
    logic [1:0]  mem_size;
    logic [3:0]  mem_strb;

    endian_bridge dut (.*);

    int n_tests = 0, n_fail = 0;
    logic [31:0] bmem [32];
    logic [31:0] cap_addr, cap_wdata, last_rd, got_rdata;
    logic [3:0]  cap_strb;
    logic        cap_write, got_err, got_pulse_ok;
    int          fwd_cnt = 0, dly = 0;

    task automatic check(string r, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    function automatic logic [31:0] swp(logic [31:0] d, logic [1:0] s);
        case (s)
            2'd1: return {d[23:16], d[31:24], d[7:0], d[15:8]};
            2'd2: return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic logic [3:0] swps(logic [3:0] b, logic [1:0] s);
        case (s)
            2'd1: return {b[2], b[3], b[0], b[1]};
            2'd2: return {b[0], b[1], b[2], b[3]};
            default: return b;
        endcase
    endfunction

    // 0 pass, 1 swap, 2 munge
    function automatic int bmode(logic [31:0] a, logic cb, logic sl);
        if (a >= win_base && a <= win_limit) return 0;
        if (cb) return 1;
        if (!sl) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] bmunge(logic [31:0] a, logic [1:0] s);
        case (s)
            2'd0: return a ^ 32'd7;
            2'd1: return a ^ 32'd6;
            default: return a ^ 32'd4;
        endcase
    endfunction

    // downstream memory model with random ready delay
    initial begin
        for (int i = 0; i < 32; i++) bmem[i] = 32'h0;
        forever @(negedge clk) begin
            mem_rsp_valid = 0;
            if (mem_ready) begin
                mem_ready = 0;
                if (cap_write)
                    for (int b = 0; b < 4; b++)
                        if (cap_strb[b]) bmem[cap_addr[6:2]][b*8 +: 8] = cap_wdata[b*8 +: 8];
                last_rd = bmem[cap_addr[6:2]];
                mem_rsp_rdata = last_rd;
                mem_rsp_valid = 1;
            end else if (mem_valid) begin
                if (dly == 0) begin
                    mem_ready = 1;
                    cap_addr = mem_addr; cap_wdata = mem_wdata;
                    cap_strb = mem_strb; cap_write = mem_write;
                    fwd_cnt++;
                    dly = $urandom % 3;
                end else dly--;
            end
        end
    end

    task automatic txn(logic [31:0] a, logic [1:0] sz, logic w, logic [31:0] wd,
                       logic [3:0] st, logic flip);
        req_addr = a; req_size = sz; req_write = w; req_wdata = wd; req_strb = st;
        req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        if (flip) begin
            cpu_big = ~cpu_big; sys_little = ~sys_little;
            win_base = 32'h0; win_limit = 32'hFFFF_FFFF;
        end
        while (!rsp_valid) @(negedge clk);
        got_rdata = rsp_rdata; got_err = rsp_err;
        @(negedge clk);
        got_pulse_ok = !rsp_valid;
    endtask

    task automatic run(string r, logic [31:0] a, logic [1:0] sz, logic w,
                       logic [31:0] wd, logic [3:0] st, logic flip);
        int m = bmode(a, cpu_big, sys_little);
        int f0 = fwd_cnt;
        logic [31:0] xa = (m == 2) ? bmunge(a, sz) : a;
        logic [31:0] xd = (m == 1) ? swp(wd, sz) : wd;
        logic [3:0]  xs = (m == 1) ? swps(st, sz) : st;
        txn(a, sz, w, wd, st, flip);
        check({r, " forwarded"}, 32'(fwd_cnt - f0), 32'd1);
        check({r, " addr"}, cap_addr, xa);
        check({r, " wdata"}, cap_wdata, xd);
        check({r, " strb"}, {28'd0, cap_strb}, {28'd0, xs});
        check({r, " R6 rdata"}, got_rdata, (m == 1) ? swp(last_rd, sz) : last_rd);
        check({r, " R8 err"}, {31'd0, got_err}, 32'd0);
        check({r, " R9 pulse"}, {31'd0, got_pulse_ok}, 32'd1);
    endtask

    task automatic bad(string r, logic [31:0] a, logic [1:0] sz);
        int f0 = fwd_cnt;
        txn(a, sz, 1'b1, 32'hDEAD_BEEF, 4'hF, 1'b0);
        check({r, " err"}, {31'd0, got_err}, 32'd1);
        check({r, " rdata"}, got_rdata, 32'd0);
        check({r, " not forwarded"}, 32'(fwd_cnt - f0), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        check("R1 mem_valid in reset", {31'd0, mem_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        // R2 swap by size
        cpu_big = 1; sys_little = 0;
        run("R2 word", 32'h10, 2'd2, 1, 32'h11223344, 4'hF, 0);
        check("R2 word literal", cap_wdata, 32'h44332211);
        run("R2 half", 32'h12, 2'd1, 1, 32'hAABBCCDD, 4'hC, 0);
        check("R2 half literal", cap_wdata, 32'hBBAADDCC);
        run("R2 byte", 32'h13, 2'd0, 1, 32'h5A000000, 4'h8, 0);
        check("R2 byte literal", cap_wdata, 32'h5A000000);

        // R10 self-inverse round trip
        run("R10 write", 32'h20, 2'd2, 1, 32'hCAFE0123, 4'hF, 0);
        run("R10 read", 32'h20, 2'd2, 0, 32'h0, 4'h0, 0);
        check("R10 roundtrip", got_rdata, 32'hCAFE0123);

        // R3 swap independent of system bit; pass-through when both little
        sys_little = 1;
        run("R3 big cpu sys little", 32'h14, 2'd2, 1, 32'h01020304, 4'hF, 0);
        check("R3 swapped", cap_wdata, 32'h04030201);
        cpu_big = 0;
        run("R3 both little", 32'h30, 2'd2, 1, 32'h01020304, 4'hF, 0);
        check("R3 pass addr", cap_addr, 32'h30);

        // R4 address rewrite
        sys_little = 0;
        run("R4 byte", 32'h02, 2'd0, 0, 32'h0, 4'h0, 0);
        check("R4 byte literal", cap_addr, 32'h05);
        run("R4 half", 32'h04, 2'd1, 1, 32'h12345678, 4'h3, 0);
        check("R4 half literal", cap_addr, 32'h02);
        run("R4 word", 32'h08, 2'd2, 1, 32'h9ABCDEF0, 4'hF, 0);
        check("R4 word literal", cap_addr, 32'h0C);

        // R5 bypass window
        run("R5 munge in window", 32'h40, 2'd0, 1, 32'h000000AA, 4'h1, 0);
        check("R5 addr kept", cap_addr, 32'h40);
        cpu_big = 1;
        run("R5 swap in window edge", 32'h4C, 2'd2, 1, 32'h11223344, 4'hF, 0);
        check("R5 data kept", cap_wdata, 32'h11223344);
        run("R5 just past window", 32'h50, 2'd2, 1, 32'h11223344, 4'hF, 0);
        check("R5 outside swapped", cap_wdata, 32'h44332211);

        // R7 controls change after acceptance
        run("R7 swap then flip", 32'h10, 2'd2, 0, 32'h0, 4'h0, 1);
        cpu_big = 0; sys_little = 0; win_base = 32'h40; win_limit = 32'h4F;
        run("R7 munge then flip", 32'h1A, 2'd1, 1, 32'h0000BEEF, 4'h3, 1);
        win_base = 32'h40; win_limit = 32'h4F;

        // R8 misaligned
        bad("R8 odd half", 32'h11, 2'd1);
        bad("R8 word off", 32'h12, 2'd2);
        bad("R8 size3", 32'h10, 2'd3);

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  sz = 2'($urandom % 3);
            logic [31:0] a = ($urandom % 128) & ~((32'd1 << sz) - 1);
            cpu_big = 1'($urandom); sys_little = 1'($urandom);
            run("R2 R4 R6 random", a, sz, 1'($urandom), $urandom, 4'($urandom), 1'($urandom % 4 == 0));
            win_base = 32'h40; win_limit = 32'h4F;
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule